// File: doc/BRIEF.md
# PHY Control-Port Access Sequencer

This block is a hardware master for the internal control-register port of a serial PHY. The port is reached through a 16-bit data-in bus, four strobes (capture address, capture data, read, write), an acknowledge line and a 16-bit data-out bus. Every strobe is closed with a full four-phase handshake: the strobe is raised, the acknowledge is awaited high, the strobe is dropped, and the acknowledge is awaited low.

A user issues one request at a time: an address, a write value and a read/write flag. A read is an address phase followed by a read-strobe phase that captures data-out. A write is an address phase followed by a capture-data phase and a write-strobe phase. Each phase first drives data-in with all strobes low for a settling window, then sets its strobe on top of the unchanged data-in value. Every wait for the acknowledge is bounded by a cycle limit from the `tmo_cycles` input. An expired wait ends the whole transaction at once with an error. The acknowledge passes through a two-flop synchronizer before the controller uses it.

Top module: `phy_cr_seq`

## Requirements
- R1: After reset, busy, done and err are low, all four strobes are low, cr_din is zero and rdata is zero.
- R2: Every phase drives its data-in value with all strobes low for at least two cycles before its strobe rises. The address phase drives req_addr and raises cr_cap_addr. Each strobe stays high until the acknowledge is seen high, and the next phase starts only after the acknowledge is seen low.
- R3: A read runs the address phase and then a read-strobe phase with cr_din equal to zero. rdata equals the cr_dout value sampled while the acknowledge is high, and it is valid when done pulses with err low.
- R4: A write runs its strobes in a fixed order: cr_cap_addr with cr_din equal to the address, then cr_cap_data with cr_din equal to the write value, then cr_wr with cr_din still equal to the write value. Each strobe completes its own handshake.
- R5: At most one strobe is high at any time. cr_din keeps its value in the cycle a strobe rises and for as long as that strobe stays high.
- R6: If any acknowledge wait lasts longer than the limit, done and err pulse together, all strobes go low, no later phase strobes, and rdata reads zero.
- R7: busy is high from the cycle after a request is accepted until the transaction ends. done is a one-cycle pulse with busy already low, and err is high only together with done.
- R8: A request presented while busy is ignored. It causes no extra strobe, and it does not change the address or data of the running transaction.
- R9: The wait limit is reloaded at the start of every acknowledge wait. A PHY whose acknowledge delay fits within the limit in each phase completes, even when the whole transaction takes many times the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Control-register address |
| req_wdata | input | 16 | Value to write |
| tmo_cycles | input | 20 | Cycle limit for each acknowledge wait |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with done |
| rdata | output | 16 | Read result, zero after a failure |
| cr_din | output | 16 | Data-in bus to the PHY port |
| cr_cap_addr | output | 1 | Capture-address strobe |
| cr_cap_data | output | 1 | Capture-data strobe |
| cr_rd | output | 1 | Read strobe |
| cr_wr | output | 1 | Write strobe |
| cr_ack | input | 1 | Acknowledge from the PHY, asynchronous |
| cr_dout | input | 16 | Data-out bus from the PHY |

## Verification
On every cycle the assertions check the local rules: strobes are mutually exclusive, data-in holds still across each strobe's rise and high time, done is a single pulse with busy low, err appears only with done, and a failed transaction leaves rdata at zero. Other behaviour spans whole transactions and depends on the PHY's responses, and only the bench scenarios can show it. This covers the order of strobes in reads and writes, the captured read value, the settling window measured in cycles, an abort that suppresses all later phases, the per-wait reload of the limit under slow acknowledges, and requests ignored while busy. The bench uses a PHY model with a programmable acknowledge delay and per-strobe muting.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

    // Phase of a transaction; the read/write flag picks the successor.
    typedef enum logic [1:0] {
        PH_ADDR = 2'd0,
        PH_RDAT = 2'd1,
        PH_CAPD = 2'd2,
        PH_WSTB = 2'd3
    } phase_e;

    // Step inside one phase: settle, strobe high, strobe released.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_HI    = 2'd2,
        ST_LO    = 2'd3
    } step_e;

    typedef struct packed {
        logic wstb;
        logic rstb;
        logic capd;
        logic capa;
    } stb_t;

    localparam int STB_N = $bits(stb_t);

    function automatic stb_t stb_of(input phase_e ph, input step_e st);
        stb_t s;
        s = '0;
        if (st == ST_HI) begin
            case (ph)
                PH_ADDR: s.capa = 1'b1;
                PH_RDAT: s.rstb = 1'b1;
                PH_CAPD: s.capd = 1'b1;
                default: s.wstb = 1'b1;
            endcase
        end
        return s;
    endfunction

    function automatic logic is_last(input phase_e ph, input logic wr);
        return wr ? (ph == PH_WSTB) : (ph == PH_RDAT);
    endfunction

    function automatic phase_e next_of(input phase_e ph, input logic wr);
        phase_e n;
        case (ph)
            PH_ADDR: n = wr ? PH_CAPD : PH_RDAT;
            PH_CAPD: n = PH_WSTB;
            default: n = ph;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/phy_cr_sync.sv
module phy_cr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/phy_cr_timer.sv
module phy_cr_timer #(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                     cnt_q <= '0;
        else if (load)               cnt_q <= limit;
        else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/phy_cr_ctrl.sv
module phy_cr_ctrl
    import phy_cr_pkg::*;
#(
    parameter int DW        = 16,
    parameter int SETUP_CYC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [DW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          ack_s,
    input  logic [DW-1:0] dout,
    input  logic          expired,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] din,
    output stb_t          stb,
    output logic          tmr_load,
    output logic          tmr_run
);
    localparam int SCW = $clog2(SETUP_CYC + 1);

    step_e          step_q;
    phase_e         phase_q;
    logic [SCW-1:0] scnt_q;
    logic           wr_q;
    logic [DW-1:0]  addr_q, wdata_q, din_q, rdata_q;
    logic           done_q, err_q;

    logic   setup_end;
    phase_e nxt_ph;
    logic   last_ph;

    assign setup_end = (step_q == ST_SETUP) && (scnt_q == SCW'(SETUP_CYC - 1));
    assign nxt_ph    = next_of(phase_q, wr_q);
    assign last_ph   = is_last(phase_q, wr_q);

    function automatic logic [DW-1:0] din_for(input phase_e ph, input logic [DW-1:0] a,
                                              input logic [DW-1:0] w);
        case (ph)
            PH_ADDR: return a;
            PH_RDAT: return '0;
            default: return w;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q  <= ST_IDLE;
            phase_q <= PH_ADDR;
            scnt_q  <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            din_q   <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (step_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        wr_q    <= req_write;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        din_q   <= req_addr;
                        phase_q <= PH_ADDR;
                        scnt_q  <= '0;
                        step_q  <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (setup_end) step_q <= ST_HI;
                    else           scnt_q <= scnt_q + 1'b1;
                end
                ST_HI: begin
                    if (ack_s) begin
                        if (phase_q == PH_RDAT) rdata_q <= dout;
                        step_q <= ST_LO;
                    end else if (expired) begin
                        step_q  <= ST_IDLE;
                        din_q   <= '0;
                        rdata_q <= '0;
                        done_q  <= 1'b1;
                        err_q   <= 1'b1;
                    end
                end
                default: begin
                    if (!ack_s) begin
                        if (last_ph) begin
                            step_q <= ST_IDLE;
                            din_q  <= '0;
                            done_q <= 1'b1;
                        end else begin
                            phase_q <= nxt_ph;
                            din_q   <= din_for(nxt_ph, addr_q, wdata_q);
                            scnt_q  <= '0;
                            step_q  <= ST_SETUP;
                        end
                    end else if (expired) begin
                        step_q  <= ST_IDLE;
                        din_q   <= '0;
                        rdata_q <= '0;
                        done_q  <= 1'b1;
                        err_q   <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign tmr_load = setup_end || ((step_q == ST_HI) && ack_s);
    assign tmr_run  = (step_q == ST_HI) || (step_q == ST_LO);
    assign busy     = (step_q != ST_IDLE);
    assign done     = done_q;
    assign err      = err_q;
    assign rdata    = rdata_q;
    assign din      = din_q;
    assign stb      = stb_of(phase_q, step_q);
endmodule

// File: rtl/phy_cr_seq.sv
module phy_cr_seq
    import phy_cr_pkg::*;
#(
    parameter int DW          = 16,
    parameter int TW          = 20,
    parameter int SETUP_CYC   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [DW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [TW-1:0] tmo_cycles,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] cr_din,
    output logic          cr_cap_addr,
    output logic          cr_cap_data,
    output logic          cr_rd,
    output logic          cr_wr,
    input  logic          cr_ack,
    input  logic [DW-1:0] cr_dout
);
    logic ack_s, expired, tmr_load, tmr_run;
    stb_t stb;

    phy_cr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(cr_ack), .q(ack_s)
    );

    phy_cr_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .run(tmr_run),
        .limit(tmo_cycles), .expired(expired)
    );

    phy_cr_ctrl #(.DW(DW), .SETUP_CYC(SETUP_CYC)) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .ack_s(ack_s), .dout(cr_dout), .expired(expired),
        .busy(busy), .done(done), .err(err), .rdata(rdata),
        .din(cr_din), .stb(stb), .tmr_load(tmr_load), .tmr_run(tmr_run)
    );

    assign cr_cap_addr = stb.capa;
    assign cr_cap_data = stb.capd;
    assign cr_rd       = stb.rstb;
    assign cr_wr       = stb.wstb;
endmodule

// File: rtl/phy_cr_seq_chk.sv
module phy_cr_seq_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic [DW-1:0] rdata,
    input logic [DW-1:0] cr_din,
    input logic          cr_cap_addr,
    input logic          cr_cap_data,
    input logic          cr_rd,
    input logic          cr_wr
);
    logic [3:0] stbs;
    assign stbs = {cr_wr, cr_rd, cr_cap_data, cr_cap_addr};

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stbs)); // R5

    AST_DIN_HELD: assert property (@(posedge clk) disable iff (rst)
        (|stbs) |-> $stable(cr_din)); // R5

    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (|stbs) |-> busy); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R7

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        err |-> done); // R6

    AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (rdata == '0)); // R6

    AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (stbs == 4'b0000)); // R6
endmodule

bind phy_cr_seq phy_cr_seq_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .err(err),
    .rdata(rdata), .cr_din(cr_din), .cr_cap_addr(cr_cap_addr),
    .cr_cap_data(cr_cap_data), .cr_rd(cr_rd), .cr_wr(cr_wr)
);

// File: tb/test_phy_cr_seq.sv
module test_phy_cr_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [19:0] tmo_cycles = 20'd50;
    logic        busy, done, err;
    logic [15:0] rdata, cr_din, cr_dout;
    logic        cr_cap_addr, cr_cap_data, cr_rd, cr_wr;
    logic        cr_ack = 1'b0;

    int n_chk = 0, n_err = 0;

    always #10 clk = ~clk; // 50 MHz

    phy_cr_seq i_phy_cr_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .tmo_cycles(tmo_cycles),
        .busy(busy), .done(done), .err(err), .rdata(rdata), .cr_din(cr_din),
        .cr_cap_addr(cr_cap_addr), .cr_cap_data(cr_cap_data), .cr_rd(cr_rd),
        .cr_wr(cr_wr), .cr_ack(cr_ack), .cr_dout(cr_dout)
    );

    // ---------------- PHY port model ----------------
    int          ack_delay = 1;
    logic [3:0]  mute = 4'b0000;   // {wr, rd, cap_data, cap_addr}
    logic [3:0]  stb_v, prev_v, rises;
    int          dly = 0;
    int          n_ca = 0, n_cd = 0, n_rd = 0, n_wr = 0;
    logic [15:0] ph_addr = '0, ph_capd = '0, ph_rd_din = '0, ph_wr_data = '0, ph_wr_addr = '0;
    logic [7:0]  order = '0;
    int          run = 0, min_setup = 1000;
    logic [15:0] din_prev = '0;

    assign stb_v   = {cr_wr, cr_rd, cr_cap_data, cr_cap_addr};
    assign rises   = stb_v & ~prev_v;
    assign cr_dout = ph_addr ^ 16'hA5C3;

    initial prev_v = '0;

    always @(posedge clk) begin
        prev_v   <= stb_v;
        din_prev <= cr_din;
        if (rst) begin
            cr_ack <= 1'b0;
            dly    <= 0;
        end else if ((|stb_v) && !cr_ack) begin
            if (|(stb_v & mute)) dly <= 0;
            else if (dly >= ack_delay) begin cr_ack <= 1'b1; dly <= 0; end
            else dly <= dly + 1;
        end else if (!(|stb_v) && cr_ack) begin
            if (dly >= ack_delay) begin cr_ack <= 1'b0; dly <= 0; end
            else dly <= dly + 1;
        end else begin
            dly <= 0;
        end
        if (rises[0]) begin n_ca <= n_ca + 1; ph_addr <= cr_din; order <= {order[5:0], 2'd0}; end
        if (rises[1]) begin n_cd <= n_cd + 1; ph_capd <= cr_din; order <= {order[5:0], 2'd1}; end
        if (rises[2]) begin n_rd <= n_rd + 1; ph_rd_din <= cr_din; order <= {order[5:0], 2'd2}; end
        if (rises[3]) begin
            n_wr <= n_wr + 1; ph_wr_data <= cr_din; ph_wr_addr <= ph_addr;
            order <= {order[5:0], 2'd3};
        end
        if (|stb_v) begin
            run <= 0;
            if ((|rises) && !rst && run < min_setup) min_setup <= run;
        end else begin
            run <= (cr_din == din_prev) ? run + 1 : 1;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic txn(input logic w, input logic [15:0] a, input logic [15:0] d,
                       input logic [19:0] t, input logic poke,
                       output logic [15:0] rd_o, output logic e_o,
                       output logic bsy_o, output logic clean_o, output logic hung_o);
        int k;
        @(negedge clk);
        tmo_cycles = t;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        bsy_o = busy;
        if (poke) begin
            repeat (3) @(negedge clk);
            req_valid = 1'b1; req_write = ~w; req_addr = a ^ 16'h00FF; req_wdata = ~d;
            @(negedge clk);
            req_valid = 1'b0;
        end
        k = 0;
        while (!done && k < 5000) begin @(negedge clk); k++; end
        hung_o = (k >= 5000);
        rd_o = rdata;
        e_o  = err;
        clean_o = !busy;
        @(negedge clk);
        clean_o = clean_o && !done && !err;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R1 status", {busy, done, err}, 0);
        chk(stb_v == 4'b0, "R1 strobes", stb_v, 0);
        chk(cr_din == 16'h0, "R1 din", cr_din, 0);
        chk(rdata == 16'h0, "R1 rdata", rdata, 0);
    endtask

    task automatic t_read(input logic [15:0] a);
        logic [15:0] r; logic e, b, c, h;
        int ca0 = n_ca, rd0 = n_rd, cd0 = n_cd, wr0 = n_wr;
        txn(1'b0, a, 16'h0, 20'd50, 1'b0, r, e, b, c, h);
        chk(!h, "R3 read completes", h, 0);
        chk(e == 1'b0, "R3 read err", e, 0);
        chk(r == (a ^ 16'hA5C3), "R3 read data", r, a ^ 16'hA5C3);
        chk(ph_addr == a, "R2 address captured", ph_addr, a);
        chk(ph_rd_din == 16'h0, "R3 din zero at read strobe", ph_rd_din, 0);
        chk(n_ca - ca0 == 1 && n_rd - rd0 == 1 && n_cd == cd0 && n_wr == wr0,
            "R3 strobe counts", {n_ca - ca0, n_rd - rd0}, 32'h1_0001);
        chk(order[3:0] == 4'b0010, "R3 strobe order", order[3:0], 4'b0010);
        chk(b == 1'b1, "R7 busy after accept", b, 1);
        chk(c == 1'b1, "R7 done one cycle, busy low", c, 1);
    endtask

    task automatic t_write(input logic [15:0] a, input logic [15:0] d);
        logic [15:0] r; logic e, b, c, h;
        int ca0 = n_ca, cd0 = n_cd, wr0 = n_wr, rd0 = n_rd;
        txn(1'b1, a, d, 20'd50, 1'b0, r, e, b, c, h);
        chk(!h && e == 1'b0, "R4 write completes", {h, e}, 0);
        chk(ph_wr_addr == a, "R4 write address", ph_wr_addr, a);
        chk(ph_capd == d, "R4 din at capture-data", ph_capd, d);
        chk(ph_wr_data == d, "R4 din at write strobe", ph_wr_data, d);
        chk(n_ca - ca0 == 1 && n_cd - cd0 == 1 && n_wr - wr0 == 1 && n_rd == rd0,
            "R4 strobe counts", {n_ca - ca0, n_cd - cd0, n_wr - wr0}, 0);
        chk(order[5:0] == 6'b00_01_11, "R4 strobe order", order[5:0], 6'b000111);
        chk(c == 1'b1, "R7 write done pulse", c, 1);
    endtask

    task automatic t_slow_ok();
        logic [15:0] r; logic e, b, c, h;
        ack_delay = 6;
        txn(1'b1, 16'h0042, 16'hBEEF, 20'd12, 1'b0, r, e, b, c, h);
        chk(!h && e == 1'b0, "R9 slow write succeeds", e, 0);
        chk(ph_wr_data == 16'hBEEF, "R9 slow write data", ph_wr_data, 16'hBEEF);
        txn(1'b0, 16'h0303, 16'h0, 20'd12, 1'b0, r, e, b, c, h);
        chk(e == 1'b0 && r == (16'h0303 ^ 16'hA5C3), "R9 slow read data", r, 16'h0303 ^ 16'hA5C3);
        ack_delay = 1;
    endtask

    task automatic t_slow_fail();
        logic [15:0] r; logic e, b, c, h;
        ack_delay = 30;
        txn(1'b0, 16'h0555, 16'h0, 20'd12, 1'b0, r, e, b, c, h);
        chk(!h && e == 1'b1, "R9 delay beyond limit fails", e, 1);
        ack_delay = 1;
        repeat (80) @(negedge clk);
    endtask

    task automatic t_tmo_addr();
        logic [15:0] r; logic e, b, c, h;
        int rd0, ca0;
        t_read(16'h1234);
        chk(rdata != 16'h0, "R6 rdata nonzero before failure", rdata, 16'h1234 ^ 16'hA5C3);
        rd0 = n_rd; ca0 = n_ca;
        mute = 4'b0001;
        txn(1'b0, 16'h2222, 16'h0, 20'd20, 1'b0, r, e, b, c, h);
        chk(!h && e == 1'b1, "R6 address timeout err", e, 1);
        chk(r == 16'h0, "R6 rdata zero after failure", r, 0);
        chk(n_rd == rd0 && n_ca - ca0 == 1, "R6 no read strobe after abort", n_rd - rd0, 0);
        chk(stb_v == 4'b0, "R6 strobes low after abort", stb_v, 0);
        mute = 4'b0000;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_tmo_wr();
        logic [15:0] r; logic e, b, c, h;
        int cd0 = n_cd, wr0 = n_wr;
        mute = 4'b1000;
        txn(1'b1, 16'h3333, 16'h4444, 20'd20, 1'b0, r, e, b, c, h);
        chk(!h && e == 1'b1, "R6 write-strobe timeout err", e, 1);
        chk(n_cd - cd0 == 1 && n_wr - wr0 == 1, "R6 phases before abort", {n_cd - cd0, n_wr - wr0}, 32'h1_0001);
        mute = 4'b0000;
        repeat (10) @(negedge clk);
        t_read(16'h00A0);
    endtask

    task automatic t_ignore();
        logic [15:0] r; logic e, b, c, h;
        int ca0 = n_ca, rd0 = n_rd, wr0 = n_wr, cd0 = n_cd;
        txn(1'b0, 16'h7A7A, 16'h0, 20'd50, 1'b1, r, e, b, c, h);
        chk(e == 1'b0 && r == (16'h7A7A ^ 16'hA5C3), "R8 running read unaffected", r, 16'h7A7A ^ 16'hA5C3);
        chk(n_ca - ca0 == 1 && n_rd - rd0 == 1 && n_wr == wr0 && n_cd == cd0,
            "R8 no extra strobes", {n_ca - ca0, n_rd - rd0}, 32'h1_0001);
        chk(ph_addr == 16'h7A7A, "R8 address kept", ph_addr, 16'h7A7A);
        repeat (5) @(negedge clk);
        chk(busy == 1'b0 && n_ca - ca0 == 1, "R8 no later transaction", busy, 0);
    endtask

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_read(16'h1010);
        t_read(16'hFFFF);
        t_write(16'h1002, 16'h7FFF);
        t_write(16'h0030, 16'h0000);
        t_slow_ok();
        t_slow_fail();
        t_tmo_addr();
        t_tmo_wr();
        t_ignore();
        chk(min_setup >= 2, "R2 settle cycles before strobe", min_setup, 2);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule